// File: doc/BRIEF.md
# Decimal Loop Stepper

The loop stepper is a sequencing controller that walks a program through up to six stages. Each accepted program pulse fires a one-cycle strobe on the output line of the current stage. It also advances a decimal (BCD) iteration counter. Each stage has its own two-digit repetition limit. When the counter reaches the limit of the current stage, the counter returns to zero and the stepper moves on to the next stage. After the last stage in use, it wraps back to the first stage. Chaining several steppers through their strobes gives nested loops.

A separate direct input lets data pick the stage. A window of pulses arrives on the direct input and is closed by a window-end pin. A window of N pulses (N from 0 to 5) selects the stage with index N, which is the (N+1)th stage. The choice takes effect on the next program pulse. Routing a sign into the direct input gives a two-way branch: no pulse picks the first stage and one pulse picks the second. Routing a digit gives a computed jump across six targets. All pins are plain control pins. There is no data stream, so there is no handshake and no back-pressure.

Top module: `loop_stepper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the current stage index is 0, the iteration count is BCD 00 and no strobe is high.
- R2: A program pulse sampled without clear produces exactly one strobe. The strobe is high for exactly one cycle, on the line of the stage in effect, in the cycle after the pulse. No strobe fires without an accepted program pulse.
- R3: The iteration count is two BCD digits (tens in bits 7:4, ones in bits 3:0). Each accepted program pulse raises it by one decimal step. It stays unchanged in cycles without a program pulse or clear.
- R4: Each stage i has a limit in bits 8i+7:8i of the limit bus, coded the same way. When the incremented count equals that limit, the count becomes 00 and the stage index goes up by one.
- R5: A limit of 00 means 100 repetitions. When the stage that completes its limit is the last one in use, as given by the stages-used input, the next stage index is 0.
- R6: A window of N direct pulses, closed by the window-end pin, makes the next program pulse act on stage index N with a count restarted from 00. N saturates at 5.
- R7: A closed window with no pulses selects stage index 0, and one with a single pulse selects stage index 1. This is the sign branch.
- R8: When a program pulse arrives in the same cycle as a window end, the pulse uses the previous selection. The new selection applies to the following pulse.
- R9: Clear forces stage index 0 and count 00. It discards any pending selection and any partial window count, and a program pulse in the same cycle produces no strobe.
- R10: A direct pulse in the same cycle as the window end is counted in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of stage, count and pending selection |
| pgm_pulse | input | 1 | Program pulse, one cycle per step |
| dir_pulse | input | 1 | Direct input pulse, counted in the open window |
| dir_done | input | 1 | Closes the direct window and latches its count |
| stages_used | input | 4 | Number of stages in use (1 to 6) |
| stage_limit | input | 48 | Per-stage BCD limits, 8 bits per stage, stage 0 lowest |
| strobe | output | 6 | One-hot program output strobes |
| cur_stage | output | 3 | Current stage index |
| iter_count | output | 8 | BCD iteration count |

## Verification
Three pairs of events can coincide. A program pulse can arrive in the same cycle as a window end. It can arrive in the same cycle as clear. A direct pulse can arrive in the same cycle as its own window end. The bench drives each of these overlaps on purpose, along with limit completion and wrap-around. A behavioural model applies the stated order: clear wins, the program pulse consumes the old selection, and the window end then latches the new one. The model's strobes, stage and count are compared against the outputs every cycle.

// File: rtl/lstep_pkg.sv
package lstep_pkg;
  // one BCD digit step: returns {carry_out, digit}
  function automatic logic [4:0] bcd_digit_step(input logic [3:0] d, input logic cin);
    if (!cin)
      return {1'b0, d};
    else if (d == 4'd9)
      return {1'b1, 4'd0};
    else
      return {1'b0, d + 4'd1};
  endfunction
endpackage

// File: rtl/lstep_burst_tally.sv
module lstep_burst_tally #(
  parameter int NUM_STAGES = 6,
  localparam int STG_W = $clog2(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dir_pulse,
  input  logic             dir_done,
  input  logic             consume,
  output logic             sel_valid,
  output logic [STG_W-1:0] sel_stage
);
  localparam logic [STG_W-1:0] BURST_MAX = STG_W'(NUM_STAGES - 1);

  logic [STG_W-1:0] tally_q;
  logic [STG_W-1:0] tally_inc;

  // saturating count including a pulse in this cycle
  assign tally_inc = (dir_pulse && tally_q != BURST_MAX) ? tally_q + STG_W'(1) : tally_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_q   <= '0;
      sel_valid <= 1'b0;
      sel_stage <= '0;
    end else if (clr) begin
      tally_q   <= '0;
      sel_valid <= 1'b0;
      sel_stage <= '0;
    end else begin
      if (dir_done) begin
        tally_q   <= '0;
        sel_valid <= 1'b1;
        sel_stage <= tally_inc;
      end else begin
        tally_q <= tally_inc;
        if (consume)
          sel_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lstep_bcd_iter.sv
module lstep_bcd_iter #(
  parameter int LIMIT_DIGITS = 2,
  localparam int CNT_W = 4 * LIMIT_DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  import lstep_pkg::*;

  logic [CNT_W-1:0]      base;
  logic [CNT_W-1:0]      next;
  logic [LIMIT_DIGITS:0] carry;

  assign base     = restart ? '0 : count;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < LIMIT_DIGITS; g++) begin : g_digit
    logic [4:0] r;
    assign r                 = bcd_digit_step(base[4*g +: 4], carry[g]);
    assign next[4*g +: 4]    = r[3:0];
    assign carry[g+1]        = r[4];
  end

  // an all-zero limit matches only on roll-over: full range
  assign hit = (next == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (step)
      count <= hit ? '0 : next;
  end
endmodule

// File: rtl/lstep_strobe_drv.sv
module lstep_strobe_drv #(
  parameter int NUM_STAGES = 6,
  localparam int STG_W = $clog2(NUM_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic [STG_W-1:0]      idx,
  output logic [NUM_STAGES-1:0] strobe
);
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        strobe[g] <= 1'b0;
      else
        strobe[g] <= fire && (idx == STG_W'(g));
    end
  end
endmodule

// File: rtl/loop_stepper.sv
module loop_stepper #(
  parameter int NUM_STAGES   = 6,
  parameter int LIMIT_DIGITS = 2,
  localparam int STG_W = $clog2(NUM_STAGES),
  localparam int CNT_W = 4 * LIMIT_DIGITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        pgm_pulse,
  input  logic                        dir_pulse,
  input  logic                        dir_done,
  input  logic [STG_W:0]              stages_used,
  input  logic [NUM_STAGES*CNT_W-1:0] stage_limit,
  output logic [NUM_STAGES-1:0]       strobe,
  output logic [STG_W-1:0]            cur_stage,
  output logic [CNT_W-1:0]            iter_count
);
  logic             step;
  logic             sel_valid;
  logic [STG_W-1:0] sel_stage;
  logic [STG_W-1:0] eff_stage;
  logic [CNT_W-1:0] eff_limit;
  logic             hit;
  logic [STG_W:0]   succ;

  assign step      = pgm_pulse && !clr;
  assign eff_stage = sel_valid ? sel_stage : cur_stage;
  assign succ      = {1'b0, eff_stage} + {{STG_W{1'b0}}, 1'b1};

  always_comb begin
    eff_limit = '0;
    for (int i = 0; i < NUM_STAGES; i++)
      if (eff_stage == STG_W'(i))
        eff_limit = stage_limit[i*CNT_W +: CNT_W];
  end

  lstep_burst_tally #(.NUM_STAGES(NUM_STAGES)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .dir_pulse(dir_pulse), .dir_done(dir_done), .consume(step),
    .sel_valid(sel_valid), .sel_stage(sel_stage)
  );

  lstep_bcd_iter #(.LIMIT_DIGITS(LIMIT_DIGITS)) u_iter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .restart(sel_valid), .limit(eff_limit),
    .count(iter_count), .hit(hit)
  );

  lstep_strobe_drv #(.NUM_STAGES(NUM_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .fire(step), .idx(eff_stage), .strobe(strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_stage <= '0;
    else if (clr)
      cur_stage <= '0;
    else if (step) begin
      if (!hit)
        cur_stage <= eff_stage;
      else if (succ >= stages_used)
        cur_stage <= '0;
      else
        cur_stage <= succ[STG_W-1:0];
    end
  end
endmodule

// File: rtl/lstep_checker.sv
module lstep_checker #(
  parameter int NUM_STAGES   = 6,
  parameter int LIMIT_DIGITS = 2,
  localparam int STG_W = $clog2(NUM_STAGES),
  localparam int CNT_W = 4 * LIMIT_DIGITS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  pgm_pulse,
  input logic [NUM_STAGES-1:0] strobe,
  input logic [STG_W-1:0]      cur_stage,
  input logic [CNT_W-1:0]      iter_count
);
  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  // R2
  strobe_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse && !clr) |=> (strobe != '0));
  // R2
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_pulse && !clr) |=> (strobe == '0));
  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cur_stage == '0 && iter_count == '0));
  // R3
  count_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_pulse && !clr) |=> ($stable(iter_count) && $stable(cur_stage)));
  // R3
  count_low_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count[3:0] <= 4'd9);
  // R4
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_stage) < NUM_STAGES);
endmodule

bind loop_stepper lstep_checker #(.NUM_STAGES(NUM_STAGES), .LIMIT_DIGITS(LIMIT_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .pgm_pulse(pgm_pulse),
  .strobe(strobe), .cur_stage(cur_stage), .iter_count(iter_count)
);

// File: tb/tb_loop_stepper.sv
module tb_loop_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, pgm_pulse = 1'b0, dir_pulse = 1'b0, dir_done = 1'b0;
  logic [3:0]  stages_used = 4'd6;
  logic [47:0] stage_limit;
  logic [5:0]  strobe;
  logic [2:0]  cur_stage;
  logic [7:0]  iter_count;

  int checks = 0, failures = 0, cycles = 0;
  string req = "R1";

  // model state
  int m_stage = 0, m_cnt = 0, m_pv = 0, m_ps = 0, m_tally = 0, m_strb = -1;

  always #10 clk = ~clk;

  loop_stepper dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pgm_pulse(pgm_pulse),
    .dir_pulse(dir_pulse), .dir_done(dir_done), .stages_used(stages_used),
    .stage_limit(stage_limit), .strobe(strobe), .cur_stage(cur_stage),
    .iter_count(iter_count)
  );

  function automatic int lim_of(int s);
    int t, o, v;
    t = int'(stage_limit[s*8+4 +: 4]);
    o = int'(stage_limit[s*8 +: 4]);
    v = t * 10 + o;
    return (v == 0) ? 100 : v;
  endfunction

  always @(posedge clk) begin
    int e, c, n;
    cycles++;
    if (!rst_n) begin
      m_stage = 0; m_cnt = 0; m_pv = 0; m_ps = 0; m_tally = 0; m_strb = -1;
    end else if (clr) begin
      m_stage = 0; m_cnt = 0; m_pv = 0; m_ps = 0; m_tally = 0; m_strb = -1;
    end else begin
      m_strb = -1;
      if (pgm_pulse) begin
        e = m_pv ? m_ps : m_stage;
        c = (m_pv ? 0 : m_cnt) + 1;
        m_pv = 0;
        m_strb = e;
        if (c == lim_of(e)) begin
          m_cnt = 0;
          m_stage = (e + 1 >= int'(stages_used)) ? 0 : e + 1;
        end else begin
          m_cnt = c % 100;
          m_stage = e;
        end
      end
      n = m_tally + (dir_pulse ? 1 : 0);
      if (n > 5) n = 5;
      if (dir_done) begin
        m_pv = 1; m_ps = n; m_tally = 0;
      end else m_tally = n;
    end
  end

  always @(negedge clk) begin
    logic [5:0] es;
    logic [7:0] ec;
    es = (m_strb < 0) ? 6'd0 : 6'(1 << m_strb);
    ec = {4'(m_cnt / 10), 4'(m_cnt % 10)};
    checks++;
    if (strobe !== es || cur_stage !== 3'(m_stage) || iter_count !== ec) begin
      failures++;
      $display("FAIL %s: strobe=%b stage=%0d count=%h expected strobe=%b stage=%0d count=%h",
               req, strobe, cur_stage, iter_count, es, m_stage, ec);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pgm_pulse = 0; dir_pulse = 0; dir_done = 0; clr = 0;
    end
  endtask

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pgm_pulse = 1;
      @(negedge clk); pgm_pulse = 0;
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic window(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dir_pulse = 1;
      @(negedge clk); dir_pulse = 0;
    end
    @(negedge clk); dir_done = 1;
    @(negedge clk); dir_done = 0;
  endtask

  initial begin
    // limits: s0=03 s1=02 s2=12 s3=01 s4=00(100) s5=05
    stage_limit = {8'h05, 8'h00, 8'h01, 8'h12, 8'h02, 8'h03};
    req = "R1"; idle(4);
    @(negedge clk); rst_n = 1;
    idle(2);
    req = "R2"; pulses(2, 1);
    req = "R3"; pulses(1, 0); pulses(1, 2);
    req = "R4"; pulses(14, 0);
    req = "R5"; pulses(1, 0); pulses(100, 0); pulses(5, 1); idle(2);
    stages_used = 4'd3;
    req = "R5"; pulses(20, 0); idle(2);
    req = "R6"; window(3); idle(1); pulses(2, 1);
    window(9); pulses(3, 0);
    req = "R7"; window(1); pulses(1, 1); window(0); pulses(1, 1);
    // R8: pulse coincides with window end
    req = "R8"; window(2); window(4);
    @(negedge clk); dir_pulse = 1;
    @(negedge clk); dir_pulse = 0; dir_done = 1; pgm_pulse = 1;
    @(negedge clk); dir_done = 0; pgm_pulse = 0;
    idle(1); pulses(2, 0);
    // R10: pulse in same cycle as window end
    req = "R10";
    @(negedge clk); dir_pulse = 1;
    @(negedge clk); dir_done = 1;
    @(negedge clk); dir_pulse = 0; dir_done = 0;
    pulses(1, 1);
    // R9: clear with pending selection and a program pulse
    req = "R9"; pulses(2, 0); window(4);
    @(negedge clk); dir_pulse = 1;
    @(negedge clk); dir_pulse = 0; clr = 1; pgm_pulse = 1;
    @(negedge clk); clr = 0; pgm_pulse = 0;
    idle(1); pulses(2, 1);
    window(2); @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; pulses(1, 1);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule